// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block divides a fast input clock for the feedback path of a fractional-N frequency synthesizer. It emits one pulse toward the phase detector per division cycle. The ratio of each cycle is an integer part plus a per-cycle offset. A third-order noise-shaping modulator produces that offset, so that over many cycles the mean ratio is the integer part plus numerator divided by modulus. The modulus is programmable and need not be a power of two.

Software presents integer, numerator and modulus words together with a load strobe. The block checks the triple. If the triple is legal it is staged, and it becomes active at the next division-cycle boundary. A rejected triple leaves the staged and active settings as they were and raises an error flag. The ratio in force for the current division cycle is brought out so that the modulator sequence can be observed.

Top module: `fracn_fb_div`

## Requirements
- R1: `div_o` is high for exactly one clock. The number of clocks from one pulse to the next equals the `ratio_o` value that appeared with the first of the two pulses. `ratio_o` changes only in a cycle where `div_o` is high.
- R2: With an active numerator of 0, every division cycle lasts exactly the active integer value.
- R3: With a nonzero numerator, every division cycle lasts between integer−3 and integer+4 clocks inclusive.
- R4: Take any run of L consecutive division cycles where L is a multiple of the modulus. The total clock count lies within 3 of L·integer + L·numerator/modulus.
- R5: A legal load does not change the cycle in progress. At the next boundary the new settings take over, the modulator state is cleared, and that first cycle lasts exactly the new integer value.
- R6: A load is rejected in three cases: the integer is below 23, the modulus is below 2, or the numerator is not below the modulus. After a rejected load, `cfg_err_o` is high from the next clock, and the division ratios continue exactly as before.
- R7: A legal load drives `cfg_err_o` low from the next clock. `cfg_err_o` changes only on the clock after a load.
- R8: After reset, `div_o` is 0, `cfg_err_o` is 0 and `ratio_o` is 32. The divider runs at a fixed ratio of 32 until a load is applied.
- R9: An integer value of 4095 with a numerator of 0 gives division cycles of exactly 4095 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_i | input | 12 | Integer part of the ratio to load |
| frac_i | input | 12 | Fractional numerator to load |
| mod_i | input | 12 | Fractional modulus to load |
| load_i | input | 1 | One-cycle strobe that samples int_i, frac_i and mod_i |
| div_o | output | 1 | Divided output pulse, one clock wide |
| ratio_o | output | 13 | Ratio of the division cycle in progress |
| cfg_err_o | output | 1 | Last load was rejected |

## Verification
A wrong modulator state appears at the ports as soon as the next boundary. It shows in `ratio_o`, and one cycle later in the measured pulse spacing. The bench compares every measured spacing with the ratio announced at the start of that cycle, and bounds it around the integer part. A carry that drifts or a modulus wrap that is off does not always break the per-cycle bounds. It does break the long-run total. The bench therefore sums cycle lengths over a whole number of modulus periods and compares the sum with the exact rational mean. A staging fault shows one boundary early or late in the spacing that follows a load.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int unsigned INT_W   = 12;
  localparam int unsigned MOD_W   = 12;
  localparam int unsigned OFS_W   = 4;
  localparam int unsigned RATIO_W = INT_W + 1;
  localparam int unsigned NSTAGE  = 3;

  typedef struct packed {
    logic [INT_W-1:0] int_v;
    logic [MOD_W-1:0] frac_v;
    logic [MOD_W-1:0] mod_v;
  } div_cfg_t;
endpackage

// File: rtl/fracn_cfg.sv
module fracn_cfg
  import fracn_pkg::*;
#(
  parameter int unsigned RST_INT = 32,
  parameter int unsigned INT_MIN = 23,
  parameter int unsigned MOD_MIN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [INT_W-1:0] int_i,
  input  logic [MOD_W-1:0] frac_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic             bound_i,
  output div_cfg_t         act_o,
  output logic [INT_W-1:0] pend_int_o,
  output logic             apply_o,
  output logic             err_o
);
  localparam div_cfg_t RST_CFG = '{int_v: INT_W'(RST_INT), frac_v: '0, mod_v: MOD_W'(MOD_MIN)};

  div_cfg_t act_q, pend_q;
  logic     pend_vld_q, err_q, legal;

  assign legal = (int_i >= INT_W'(INT_MIN)) && (mod_i >= MOD_W'(MOD_MIN)) && (frac_i < mod_i);
  assign apply_o = bound_i & pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= RST_CFG;
      pend_q     <= RST_CFG;
      pend_vld_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (apply_o) begin
        act_q      <= pend_q;
        pend_vld_q <= 1'b0;
      end
      // a load in the same cycle as an apply stays pending for the next boundary
      if (load_i) begin
        if (legal) begin
          pend_q     <= '{int_v: int_i, frac_v: frac_i, mod_v: mod_i};
          pend_vld_q <= 1'b1;
          err_q      <= 1'b0;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign act_o      = act_q;
  assign pend_int_o = pend_q.int_v;
  assign err_o      = err_q;
endmodule

// File: rtl/fracn_mash3.sv
module fracn_mash3
  import fracn_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic [MOD_W-1:0] frac_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [MOD_W-1:0] acc_q [NSTAGE];
  logic [MOD_W-1:0] acc_d [NSTAGE];
  logic             cy    [NSTAGE];
  logic             c2_q, c3_q, c3_qq;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    logic [MOD_W-1:0] addend;
    logic [MOD_W:0]   sum;
    if (k == 0) begin : g_first
      assign addend = frac_i;
    end else begin : g_next
      assign addend = acc_d[k-1];
    end
    assign sum      = {1'b0, acc_q[k]} + {1'b0, addend};
    assign cy[k]    = (sum >= {1'b0, mod_i});
    // wrap at the modulus, not at a power of two
    assign acc_d[k] = cy[k] ? MOD_W'(sum - {1'b0, mod_i}) : sum[MOD_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_q[k] <= '0;
      else if (clr_i)  acc_q[k] <= '0;
      else if (step_i) acc_q[k] <= acc_d[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_q  <= 1'b0;
      c3_q  <= 1'b0;
      c3_qq <= 1'b0;
    end else if (clr_i) begin
      c2_q  <= 1'b0;
      c3_q  <= 1'b0;
      c3_qq <= 1'b0;
    end else if (step_i) begin
      c2_q  <= cy[1];
      c3_q  <= cy[2];
      c3_qq <= c3_q;
    end
  end

  // c1 + (c2 - c2') + (c3 - 2c3' + c3''), two's complement, range -3..+4
  assign ofs_o = OFS_W'(cy[0]) + OFS_W'(cy[1]) - OFS_W'(c2_q)
               + OFS_W'(cy[2]) - OFS_W'({c3_q, 1'b0}) + OFS_W'(c3_qq);
endmodule

// File: rtl/fracn_cnt.sv
module fracn_cnt
  import fracn_pkg::*;
#(
  parameter int unsigned RST_INT = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] nxt_i,
  output logic               tick_o,
  output logic               div_o,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [RATIO_W-1:0] cnt_q, ratio_q;
  logic               div_q;

  assign tick_o = (cnt_q == RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= RATIO_W'(RST_INT);
      ratio_q <= RATIO_W'(RST_INT);
      div_q   <= 1'b0;
    end else if (tick_o) begin
      cnt_q   <= nxt_i;
      ratio_q <= nxt_i;
      div_q   <= 1'b1;
    end else begin
      cnt_q <= cnt_q - RATIO_W'(1);
      div_q <= 1'b0;
    end
  end

  assign div_o   = div_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/fracn_fb_div.sv
module fracn_fb_div
  import fracn_pkg::*;
#(
  parameter int unsigned RST_INT = 32,
  parameter int unsigned INT_MIN = 23,
  parameter int unsigned MOD_MIN = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INT_W-1:0]   int_i,
  input  logic [MOD_W-1:0]   frac_i,
  input  logic [MOD_W-1:0]   mod_i,
  input  logic               load_i,
  output logic               div_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               cfg_err_o
);
  div_cfg_t           act;
  logic [INT_W-1:0]   pend_int, act_int;
  logic [MOD_W-1:0]   act_frac;
  logic               tick, apply;
  logic [OFS_W-1:0]   ofs;
  logic [RATIO_W-1:0] nxt;

  fracn_cfg #(.RST_INT(RST_INT), .INT_MIN(INT_MIN), .MOD_MIN(MOD_MIN)) u_cfg (
    .clk_i, .rst_ni, .load_i, .int_i, .frac_i, .mod_i,
    .bound_i(tick), .act_o(act), .pend_int_o(pend_int), .apply_o(apply), .err_o(cfg_err_o)
  );

  assign act_int  = act.int_v;
  assign act_frac = act.frac_v;

  fracn_mash3 u_mod (
    .clk_i, .rst_ni, .step_i(tick & ~apply), .clr_i(apply),
    .frac_i(act_frac), .mod_i(act.mod_v), .ofs_o(ofs)
  );

  // new settings start with a pure-integer cycle
  assign nxt = apply ? RATIO_W'(pend_int)
                     : RATIO_W'(act_int) + {{(RATIO_W-OFS_W){ofs[OFS_W-1]}}, ofs};

  fracn_cnt #(.RST_INT(RST_INT)) u_cnt (
    .clk_i, .rst_ni, .nxt_i(nxt), .tick_o(tick), .div_o, .ratio_o
  );
endmodule

// File: rtl/fracn_chk.sv
module fracn_chk
  import fracn_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               div_o,
  input logic               cfg_err_o,
  input logic [RATIO_W-1:0] ratio_o,
  input logic [INT_W-1:0]   act_int,
  input logic [MOD_W-1:0]   act_frac
);
  // R1
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  // R1
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_o) |-> div_o);

  // R2
  int_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o && act_frac == '0) |-> (int'(ratio_o) == int'(act_int)));

  // R3
  ratio_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> (int'(ratio_o) >= int'(act_int) - 3 && int'(ratio_o) <= int'(act_int) + 4));

  // R7
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_err_o));

  // R6
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> $past(load_i));
endmodule

bind fracn_fb_div fracn_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .div_o(div_o),
  .cfg_err_o(cfg_err_o), .ratio_o(ratio_o), .act_int(act_int), .act_frac(act_frac)
);

// File: tb/sim_fracn_fb_div.sv
`timescale 1ns/1ps
module sim_fracn_fb_div;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] int_i = '0, frac_i = '0, mod_i = '0;
  logic        load_i = 1'b0;
  logic        div_o, cfg_err_o;
  logic [12:0] ratio_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fracn_fb_div u0 (
    .clk_i(clk), .rst_ni(rst_ni), .int_i(int_i), .frac_i(frac_i), .mod_i(mod_i),
    .load_i(load_i), .div_o(div_o), .ratio_o(ratio_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!div_o);
  endtask

  task automatic do_load(input int iv, input int fv, input int mv);
    int_i = 12'(iv); frac_i = 12'(fv); mod_i = 12'(mv); load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // loads at a boundary, checks deferral, cleared start and first cycle
  task automatic run_load(input int iv, input int fv, input int mv);
    int c, old_r;
    wait_pulse(c);
    old_r = int'(ratio_o);
    do_load(iv, fv, mv);
    chk(cfg_err_o == 1'b0, "R7 err after legal load", int'(cfg_err_o), 0);
    wait_pulse(c);
    chk(c + 1 == old_r, "R5 cycle in progress kept", c + 1, old_r);
    chk(int'(ratio_o) == iv, "R5 first ratio after apply", int'(ratio_o), iv);
    wait_pulse(c);
    chk(c == iv, "R5 first cycle is pure integer", c, iv);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(div_o == 1'b0, "R8 div_o in reset", int'(div_o), 0);
    chk(int'(ratio_o) == 32, "R8 ratio_o in reset", int'(ratio_o), 32);
    chk(cfg_err_o == 1'b0, "R8 err in reset", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    begin
      int c;
      wait_pulse(c);
      wait_pulse(c);
      chk(c == 32, "R8 default period", c, 32);
    end
  endtask

  task automatic t_int(input int iv, input int n);
    int c;
    wait_pulse(c);
    @(negedge clk);
    chk(div_o == 1'b0, "R1 pulse one clock wide", int'(div_o), 0);
    wait_pulse(c);
    chk(c + 1 == iv, "R2 integer period", c + 1, iv);
    for (int i = 0; i < n; i++) begin
      wait_pulse(c);
      chk(c == iv, "R2 integer period", c, iv);
      chk(int'(ratio_o) == iv, "R2 ratio_o", int'(ratio_o), iv);
    end
  endtask

  task automatic t_reject(input int iv, input int fv, input int mv, input int keep);
    int c;
    wait_pulse(c);
    do_load(iv, fv, mv);
    chk(cfg_err_o == 1'b1, "R6 err on illegal load", int'(cfg_err_o), 1);
    wait_pulse(c);
    chk(c + 1 == keep, "R6 period kept", c + 1, keep);
    wait_pulse(c);
    chk(c == keep, "R6 config kept", c, keep);
    chk(cfg_err_o == 1'b1, "R7 err holds without load", int'(cfg_err_o), 1);
  endtask

  task automatic t_frac(input int iv, input int fv, input int mv, input int len, input bit avg);
    int c, prev, sum, diff;
    sum = 0;
    repeat (3) wait_pulse(c);
    prev = int'(ratio_o);
    for (int i = 0; i < len; i++) begin
      wait_pulse(c);
      if (c != prev) chk(0, "R1 period equals announced ratio", c, prev);
      if (c < iv - 3 || c > iv + 4) chk(0, "R3 ratio range", c, iv);
      sum += c;
      prev = int'(ratio_o);
    end
    chk(1, "R1 R3 sequence", 0, 0);
    if (avg) begin
      diff = sum - len * iv - (len * fv) / mv;
      chk(diff >= -3 && diff <= 3, "R4 long-run mean", sum, len * iv + (len * fv) / mv);
    end
  endtask

  initial begin
    t_reset();
    run_load(25, 0, 2);
    t_int(25, 5);
    t_reject(22, 0, 2, 25);
    t_reject(40, 0, 1, 25);
    t_reject(40, 5, 5, 25);
    run_load(30, 1, 3);
    t_frac(30, 1, 3, 30, 1'b1);
    run_load(40, 5, 7);
    t_frac(40, 5, 7, 70, 1'b1);
    run_load(100, 3, 16);
    t_frac(100, 3, 16, 32, 1'b1);
    run_load(23, 4094, 4095);
    t_frac(23, 4094, 4095, 60, 1'b0);
    run_load(4095, 0, 2);
    begin
      int c;
      wait_pulse(c);
      chk(c == 4095, "R9 maximum integer period", c, 4095);
    end
    run_load(26, 0, 2);
    t_int(26, 3);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule